// File: doc/BRIEF.md
# Interrupt-on-change GPIO port expander core

The block is the register-file core of a general-purpose I/O expander with eight pins per bank and one or two banks. A host reaches it over a plain synchronous register bus (address, write data, write strobe, read strobe, registered read data). For each pin the core holds a direction bit, an output latch, an input-inversion bit and a stored pull-up bit. It drives pin outputs with matching output enables and samples pin inputs through a two-flop synchroniser.

Each bank watches its enabled input pins. In change mode a pin triggers when its value departs from the value last seen. In compare mode a pin triggers while its value differs from a programmed default. The first triggering pin latches a flag, and a snapshot of the whole bank is taken. Both stay frozen until a clearing read. Per-bank interrupt outputs support active-high or active-low push-pull, open-drain and cross-bank mirroring. The serial front end, address pins and analog pull-ups sit outside the block.

Top module: `gpx_expander`

## Requirements
- R1: After reset every pin is an input (pin_oe_o all 0) and the direction register reads 0xFF. Every other register reads 0x00, and each interrupt output is at its inactive level.
- R2: Register index i of bank b sits at address 2*i+b with two banks, or at address i with one bank. Indices: 0 direction (1 = input), 1 input inversion, 2 interrupt enable, 3 compare default, 4 interrupt mode (1 = compare), 5 configuration, 6 pull-up, 7 flag, 8 capture, 9 port, 10 output latch. Read data appears one cycle after the read strobe, and unmapped addresses read 0. The writable registers (0 to 6 and 10) read back what was written.
- R3: pin_out_o equals the output latch, and pin_oe_o is the inverse of the direction register.
- R4: A port read returns, for input pins, the pin value after two synchroniser flops XOR the inversion bit, and the latch bit for output pins.
- R5: With mode bit 0, an enabled input pin flags when its port value differs from the previous value. Pins with enable 0 never flag.
- R6: With mode bit 1, an enabled input pin flags while its port value differs from its compare-default bit.
- R7: A bank's flag register holds at most one set bit: the lowest-numbered pin that triggers in the flagging cycle. The capture register then holds the bank's port value. Neither changes until the bank is cleared.
- R8: Configuration bit 0 = 0: a read of the bank's port register clears its flag and its pending interrupt. Bit 0 = 1: a read of its capture register does this instead. The capture value is kept after a clear.
- R9: Configuration bit 1 sets the interrupt polarity (1 = active high). In push-pull mode irq_oe_o is 1 and irq_o carries the level.
- R10: Configuration bit 2 selects open-drain. irq_o is then 0 and irq_oe_o is 1 only while the interrupt is active, whatever the polarity bit.
- R11: Configuration bit 6 of a bank makes its interrupt output active also when the other bank is pending. Without it, each output follows only its own bank.
- R12: Writes to flag, capture and port registers change nothing. Activity on one bank leaves the other bank's flag and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after re_i |
| pin_in_i | input | 8*NUM_BANKS | Pin input values |
| pin_out_o | output | 8*NUM_BANKS | Pin output values |
| pin_oe_o | output | 8*NUM_BANKS | Pin output enables |
| irq_o | output | NUM_BANKS | Interrupt output level per bank |
| irq_oe_o | output | NUM_BANKS | Interrupt output drive enable per bank |

## Verification
The assertions assume that we_i and re_i are never raised together. They also assume that a read strobe lasts a single cycle, so one clearing read cannot be counted twice. The bench drives every strobe for exactly one cycle from tasks that set inputs on the falling edge. It holds pin inputs steady for several cycles after each change, so that the synchroniser and flag timing are never raced. While the random phase checks the port and pin paths, interrupt enables stay at zero. Interrupts are then exercised only by directed sequences whose flag and capture values are known in advance.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int ADDR_W = 5;
  localparam int BANK_W = 8;

  typedef enum logic [3:0] {
    RI_DIR  = 4'd0,
    RI_INV  = 4'd1,
    RI_IEN  = 4'd2,
    RI_DEF  = 4'd3,
    RI_MODE = 4'd4,
    RI_CFG  = 4'd5,
    RI_PUP  = 4'd6,
    RI_FLAG = 4'd7,
    RI_CAP  = 4'd8,
    RI_PORT = 4'd9,
    RI_LAT  = 4'd10
  } reg_idx_e;

  localparam logic [3:0] RI_LAST = 4'd10;

  // configuration bit positions
  localparam int CFG_CLRSRC = 0;
  localparam int CFG_POL    = 1;
  localparam int CFG_OD     = 2;
  localparam int CFG_MIRROR = 6;
endpackage

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [3:0]        idx_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] pin_i,
  output logic [BANK_W-1:0] pin_out_o,
  output logic [BANK_W-1:0] pin_oe_o,
  output logic              pend_o,
  output logic              cfg_pol_o,
  output logic              cfg_od_o,
  output logic              cfg_mirror_o
);
  logic [BANK_W-1:0] dir_q, inv_q, ien_q, def_q, mode_q, cfg_q, pup_q, lat_q;
  logic [BANK_W-1:0] flag_q, cap_q, prev_q;
  logic [BANK_W-1:0] sync1_q, sync2_q;
  logic [BANK_W-1:0] port_v, cond, first_hit;
  logic              pend_q, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  assign port_v = (dir_q & (sync2_q ^ inv_q)) | (~dir_q & lat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      inv_q  <= '0;
      ien_q  <= '0;
      def_q  <= '0;
      mode_q <= '0;
      cfg_q  <= '0;
      pup_q  <= '0;
      lat_q  <= '0;
    end else if (we_i) begin
      case (idx_i)
        RI_DIR:  dir_q  <= wdata_i;
        RI_INV:  inv_q  <= wdata_i;
        RI_IEN:  ien_q  <= wdata_i;
        RI_DEF:  def_q  <= wdata_i;
        RI_MODE: mode_q <= wdata_i;
        RI_CFG:  cfg_q  <= wdata_i;
        RI_PUP:  pup_q  <= wdata_i;
        RI_LAT:  lat_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // trigger per pin: compare against default or against last seen value
  assign cond = ien_q & dir_q &
                ((mode_q & (port_v ^ def_q)) | (~mode_q & (port_v ^ prev_q)));
  assign first_hit = cond & (~cond + 1'b1);

  assign clr = re_i && (cfg_q[CFG_CLRSRC] ? (idx_i == RI_CAP) : (idx_i == RI_PORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      flag_q <= '0;
      cap_q  <= '0;
      prev_q <= '0;
    end else begin
      if (!pend_q) prev_q <= port_v;
      if (clr) begin
        pend_q <= 1'b0;
        flag_q <= '0;
      end else if (!pend_q && (|cond)) begin
        pend_q <= 1'b1;
        flag_q <= first_hit;
        cap_q  <= port_v;
      end
    end
  end

  always_comb begin
    case (idx_i)
      RI_DIR:  rdata_o = dir_q;
      RI_INV:  rdata_o = inv_q;
      RI_IEN:  rdata_o = ien_q;
      RI_DEF:  rdata_o = def_q;
      RI_MODE: rdata_o = mode_q;
      RI_CFG:  rdata_o = cfg_q;
      RI_PUP:  rdata_o = pup_q;
      RI_FLAG: rdata_o = flag_q;
      RI_CAP:  rdata_o = cap_q;
      RI_PORT: rdata_o = port_v;
      RI_LAT:  rdata_o = lat_q;
      default: rdata_o = '0;
    endcase
  end

  assign pin_out_o    = lat_q;
  assign pin_oe_o     = ~dir_q;
  assign pend_o       = pend_q;
  assign cfg_pol_o    = cfg_q[CFG_POL];
  assign cfg_od_o     = cfg_q[CFG_OD];
  assign cfg_mirror_o = cfg_q[CFG_MIRROR];

  assert_one_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_q));
  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr) |=> ($stable(flag_q) && $stable(cap_q)));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (flag_q == '0 && $stable(cap_q)));
  assert_pend_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> ($countones(flag_q) == 1));
endmodule

// File: rtl/gpx_irq_drv.sv
module gpx_irq_drv #(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] pend_i,
  input  logic [NUM_BANKS-1:0] pol_i,
  input  logic [NUM_BANKS-1:0] od_i,
  input  logic [NUM_BANKS-1:0] mirror_i,
  output logic [NUM_BANKS-1:0] irq_o,
  output logic [NUM_BANKS-1:0] irq_oe_o
);
  logic [NUM_BANKS-1:0] act;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_out
    assign act[b]      = pend_i[b] | (mirror_i[b] & pend_i[(b + 1) % NUM_BANKS]);
    assign irq_o[b]    = od_i[b] ? 1'b0 : (act[b] ? pol_i[b] : ~pol_i[b]);
    assign irq_oe_o[b] = od_i[b] ? act[b] : 1'b1;

    assert_od_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (od_i[b] && !pend_i[b] && !pend_i[(b + 1) % NUM_BANKS]) |-> !irq_oe_o[b]);
    assert_own_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[b] && !od_i[b]) |-> (irq_o[b] == pol_i[b]));
  end
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int NPINS = BANK_W * NUM_BANKS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BANK_W-1:0]    wdata_i,
  input  logic                 we_i,
  input  logic                 re_i,
  output logic [BANK_W-1:0]    rdata_o,
  input  logic [NPINS-1:0]     pin_in_i,
  output logic [NPINS-1:0]     pin_out_o,
  output logic [NPINS-1:0]     pin_oe_o,
  output logic [NUM_BANKS-1:0] irq_o,
  output logic [NUM_BANKS-1:0] irq_oe_o
);
  logic [3:0]           idx;
  logic                 hit;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend, pol, od, mirror;
  logic [BANK_W-1:0]    rd_mux, rdata_q;

  if (NUM_BANKS == 2) begin : g_dec2
    assign idx      = addr_i[4:1];
    assign hit      = (idx <= RI_LAST);
    assign bank_hit = {hit & addr_i[0], hit & ~addr_i[0]};
  end else begin : g_dec1
    assign idx      = addr_i[3:0];
    assign hit      = !addr_i[4] && (idx <= RI_LAST);
    assign bank_hit = hit;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpx_bank u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (we_i & bank_hit[b]),
      .re_i         (re_i & bank_hit[b]),
      .idx_i        (idx),
      .wdata_i      (wdata_i),
      .rdata_o      (bank_rd[b]),
      .pin_i        (pin_in_i[b*BANK_W +: BANK_W]),
      .pin_out_o    (pin_out_o[b*BANK_W +: BANK_W]),
      .pin_oe_o     (pin_oe_o[b*BANK_W +: BANK_W]),
      .pend_o       (pend[b]),
      .cfg_pol_o    (pol[b]),
      .cfg_od_o     (od[b]),
      .cfg_mirror_o (mirror[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_hit[b]) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  gpx_irq_drv #(.NUM_BANKS(NUM_BANKS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .pol_i    (pol),
    .od_i     (od),
    .mirror_i (mirror),
    .irq_o    (irq_o),
    .irq_oe_o (irq_oe_o)
  );

  assert_bus_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
  assert_unmapped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !hit) |=> (rdata_o == '0));
endmodule

// File: tb/gpx_expander_tb.sv
`timescale 1ns/1ps
module gpx_expander_tb_top;
  localparam int NB = 2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] pins = '0;
  logic [15:0] pout, poe;
  logic [1:0]  irq, irq_oe;

  int checks = 0, errors = 0;
  logic [7:0] m_dir [2], m_inv [2], m_lat [2];

  always #2.5 clk = ~clk;

  gpx_expander #(.NUM_BANKS(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pin_in_i(pins),
    .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  function automatic logic [4:0] ad(input int idx, input int b);
    return 5'(idx * 2 + b);
  endfunction

  function automatic logic [7:0] port_exp(input int b, input logic [7:0] p);
    return (m_dir[b] & (p ^ m_inv[b])) | (~m_dir[b] & m_lat[b]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < 2; b++) begin m_dir[b] = 8'hFF; m_inv[b] = 8'h00; m_lat[b] = 8'h00; end
    settle(3); rst_n = 1'b1; settle(2);

    // R1 reset state
    chk("R1 oe", 32'(poe), 32'h0);
    rd(ad(0,0), d); chk("R1 dirA", 32'(d), 32'hFF);
    rd(ad(0,1), d); chk("R1 dirB", 32'(d), 32'hFF);
    rd(ad(5,0), d); chk("R1 cfgA", 32'(d), 32'h00);
    rd(ad(10,1), d); chk("R1 latB", 32'(d), 32'h00);
    chk("R1 irq", 32'({irq, irq_oe}), 32'b1111);

    // R2 readback and unmapped address
    wr(ad(6,1), 8'hA5); rd(ad(6,1), d); chk("R2 pullup B", 32'(d), 32'hA5);
    rd(ad(6,0), d); chk("R2 pullup A untouched", 32'(d), 32'h00);
    rd(5'd23, d); chk("R2 unmapped", 32'(d), 32'h00);

    // R3 directed
    wr(ad(0,0), 8'hF0); m_dir[0] = 8'hF0;
    wr(ad(10,0), 8'h5A); m_lat[0] = 8'h5A;
    chk("R3 out", 32'(pout[7:0]), 32'h5A);
    chk("R3 oe", 32'(poe[7:0]), 32'h0F);

    // R4 random port path
    for (int it = 0; it < 60; it++) begin
      int b;
      logic [7:0] v;
      b = int'($urandom % 2);
      v = 8'($urandom);
      case ($urandom % 4)
        0: begin wr(ad(0,b), v); m_dir[b] = v; end
        1: begin wr(ad(1,b), v); m_inv[b] = v; end
        2: begin wr(ad(10,b), v); m_lat[b] = v; end
        default: pins[b*8 +: 8] = v;
      endcase
      settle(3);
      rd(ad(9,b), d);
      chk("R4 port", 32'(d), 32'(port_exp(b, pins[b*8 +: 8])));
      chk("R3 pins", 32'({pout, poe}),
          32'({m_lat[1], m_lat[0], ~m_dir[1], ~m_dir[0]}));
    end

    // interrupt setup
    for (int b = 0; b < 2; b++) begin
      wr(ad(0,b), 8'hFF); m_dir[b] = 8'hFF;
      wr(ad(1,b), 8'h00); m_inv[b] = 8'h00;
    end
    pins = '0; settle(4);
    rd(ad(9,0), d); rd(ad(9,1), d);

    // R5 change mode on bank A
    wr(ad(2,0), 8'h0C);
    pins[7:0] = 8'h01; settle(4);
    rd(ad(7,0), d); chk("R5 disabled pin no flag", 32'(d), 32'h00);
    pins[7:0] = 8'h0D; settle(4);
    chk("R9 active low", 32'({irq_oe[0], irq[0]}), 32'b10);
    rd(ad(7,0), d); chk("R7 lowest flag", 32'(d), 32'h04);
    rd(ad(8,0), d); chk("R7 capture", 32'(d), 32'h0D);
    pins[7:0] = 8'h05; settle(4);
    rd(ad(7,0), d); chk("R7 flag frozen", 32'(d), 32'h04);
    rd(ad(8,0), d); chk("R7 capture frozen", 32'(d), 32'h0D);
    pins[7:0] = 8'h0D; settle(4);
    rd(ad(9,0), d); chk("R8 port read", 32'(d), 32'h0D);
    settle(1);
    chk("R8 irq released", 32'(irq[0]), 32'h1);
    rd(ad(7,0), d); chk("R8 flag cleared", 32'(d), 32'h00);
    rd(ad(8,0), d); chk("R8 capture kept", 32'(d), 32'h0D);

    // R6 compare mode on bank B, clear by capture read, active high
    wr(ad(5,1), 8'h03);
    wr(ad(4,1), 8'h01);
    wr(ad(3,1), 8'h00);
    wr(ad(2,1), 8'h01);
    settle(3);
    chk("R9 inactive high", 32'(irq[1]), 32'h0);
    pins[8] = 1'b1; settle(4);
    chk("R6 irq B", 32'({irq_oe[1], irq[1]}), 32'b11);
    chk("R11 no mirror", 32'(irq[0]), 32'h1);
    rd(ad(7,1), d); chk("R6 flag B", 32'(d), 32'h01);
    rd(ad(9,1), d); rd(ad(7,1), d); chk("R8 port read no clear", 32'(d), 32'h01);
    pins[8] = 1'b0; settle(4);
    rd(ad(8,1), d); chk("R8 capture B", 32'(d), 32'h01);
    settle(1);
    chk("R8 irq B cleared", 32'(irq[1]), 32'h0);
    rd(ad(7,1), d); chk("R12 flag B", 32'(d), 32'h00);
    rd(ad(7,0), d); chk("R12 bank A untouched", 32'(d), 32'h00);

    // R10, R11 open drain and mirror on bank A output
    wr(ad(5,0), 8'h46);
    settle(1);
    chk("R10 released", 32'({irq_oe[0], irq[0]}), 32'b00);
    pins[8] = 1'b1; settle(4);
    chk("R11 mirrored od", 32'({irq_oe[0], irq[0]}), 32'b10);
    pins[8] = 1'b0; settle(4);
    rd(ad(8,1), d); settle(1);
    chk("R10 od release", 32'(irq_oe[0]), 32'h0);

    // R12 read-only registers ignore writes
    wr(ad(7,0), 8'hFF); rd(ad(7,0), d); chk("R12 flag write", 32'(d), 32'h00);
    wr(ad(8,0), 8'hFF); rd(ad(8,0), d); chk("R12 capture write", 32'(d), 32'h0D);
    wr(ad(9,0), 8'hFF); chk("R12 port write", 32'(pout[7:0]), 32'(m_lat[0]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule